// File: doc/BRIEF.md
# Dual Power-Channel Control Register Slave

This block is a two-wire serial slave that sits in front of the control logic of two power channels. It holds two small system registers, one per channel, and drives their bits straight out as per-channel control signals: output enable, high-voltage select, cable-drop compensation, continuous tone enable, current-limit range, and a shared dynamic current-limit mode. The bus lines are oversampled by the system clock, so SCL may run at up to 400 kHz against a much faster core clock. The slave drives SDA through an open-drain enable (`sda_oe` high pulls the line low).

A write transfer carries one or more data bytes. The top bit of each byte chooses the register and the remaining bits land in that register's writable field. A read transfer returns the first register, then the second, alternating for as long as the master keeps acknowledging. The read bytes carry live overload flags for each channel and a live overtemperature flag. While the power-good input is low the slave is deaf and both registers stay at zero. A rising edge on the overtemperature flag wipes the written settings, so both channels go back to disabled.

Top module: `lnb_ctrl_i2c`

## Requirements
- R1: The slave answers only to the 7-bit address 0001 00A, where A is `addr_sel`; the eighth address bit is R/W with 1 meaning read. A transfer to any other address gets no acknowledge and changes no register.
- R2: After a matching address byte, and after every data byte of a write, the slave pulls SDA low (`sda_oe` high) for the ninth clock.
- R3: Bit 7 of a written byte selects the register (0 = channel 1, 1 = channel 2). For channel 1, bits 6..1 set dynamic limit, current range, tone, compensation, high voltage and enable, in that order from bit 6 down. For channel 2, bits 5..1 set current range, tone, compensation, high voltage and enable. Bit 0, and bit 6 of a channel 2 byte, are ignored. The control outputs follow the registers.
- R4: Every data byte of a multi-byte write is decoded on its own through its own bit 7.
- R5: Read bytes go out MSB first, and SDA changes only while SCL is low. Channel 1 reads as {0, its six bits, channel 1 overload}. Channel 2 reads as {1, channel 2 overload, its five bits, overtemperature}. The flags are read live.
- R6: A read starts with channel 1 and then alternates. A master ACK asks for another byte, and a NACK ends the read with SDA released.
- R7: After reset both registers are zero, every control output is low and `sda_oe` is low.
- R8: While `pwr_good` is low, both registers are held at zero, no byte is acknowledged and `sda_oe` stays low. A write attempted during that time has no effect after power returns.
- R9: A rising edge of `otf` clears all writable bits of both registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | High pulls SDA low |
| addr_sel | input | 1 | Low bit of the slave address |
| pwr_good | input | 1 | Supply good; low disables the slave and clears registers |
| olf1 | input | 1 | Channel 1 overload flag |
| olf2 | input | 1 | Channel 2 overload flag |
| otf | input | 1 | Overtemperature flag |
| dyn_limit | output | 1 | Dynamic current-limit mode |
| ilim_hi | output | 2 | High current-limit range, index 0 = channel 1 |
| tone_on | output | 2 | Continuous tone enable per channel |
| cable_comp | output | 2 | Cable-drop compensation per channel |
| hi_volt | output | 2 | High output voltage select per channel |
| chan_en | output | 2 | Channel enable |

## Verification
The assertions assume that the master obeys the bus rules. SDA from the master moves only while SCL is low, each SCL phase lasts many core clocks, a STOP is never issued while the slave holds SDA, and the flag inputs are synchronous to `clk`. The bench drives every bus phase for a dozen core clocks, changes its SDA only a full phase after a falling SCL, and releases SDA whenever the slave may drive. It moves `pwr_good` and `otf` only while the bus is idle.

// File: rtl/lnbi2c_pkg.sv
package lnbi2c_pkg;
  localparam int BYTE_W  = 8;
  localparam int CH1_W   = 6;
  localparam int CH2_W   = 5;
  localparam int SEL_BIT = BYTE_W - 1;
  localparam int CNT_W   = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } link_st_e;
endpackage

// File: rtl/lnb_bus_sync.sv
module lnb_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic              scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_p  <= scl_sr[STAGES-1];
      sda_p  <= sda_sr[STAGES-1];
    end
  end

  assign scl_s     = scl_sr[STAGES-1];
  assign sda_s     = sda_sr[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/lnb_link_fsm.sv
module lnb_link_fsm
  import lnbi2c_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b000100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              addr_sel,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              rd_sel,
  output logic              wr_stb,
  output logic [BYTE_W-1:1] wr_data,
  output logic              sda_oe
);
  link_st_e          st, st_d;
  logic [CNT_W-1:0]  cnt, cnt_d;
  logic [BYTE_W-1:0] sh, sh_d;
  logic              oe_d, rsel_d, rd, rd_d, wstb_d, mack, mack_d;
  logic              full;

  assign full = (cnt == CNT_W'(BYTE_W));

  always_comb begin
    st_d   = st;
    cnt_d  = cnt;
    sh_d   = sh;
    oe_d   = sda_oe;
    rsel_d = rd_sel;
    rd_d   = rd;
    wstb_d = 1'b0;
    mack_d = mack;
    if (!pwr_good) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (start_det) begin
      st_d   = ST_ADDR;
      cnt_d  = '0;
      oe_d   = 1'b0;
      rsel_d = 1'b0;
    end else if (stop_det) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise && !full) begin
            sh_d  = {sh[BYTE_W-2:0], sda_s};
            cnt_d = cnt + 1'b1;
          end else if (scl_fall && full) begin
            if (st == ST_WDATA) begin
              st_d   = ST_WACK;
              oe_d   = 1'b1;
              wstb_d = 1'b1;
            end else if (sh[BYTE_W-1:1] == {ADDR_HI, addr_sel}) begin
              st_d = ST_AACK;
              oe_d = 1'b1;
              rd_d = sh[0];
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_AACK, ST_WACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (st == ST_AACK && rd) begin
              sh_d   = rd_byte;
              oe_d   = ~rd_byte[BYTE_W-1];
              rsel_d = ~rd_sel;
              st_d   = ST_RDATA;
            end else begin
              oe_d = 1'b0;
              st_d = ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_d = cnt + 1'b1;
          end else if (scl_fall) begin
            if (full) begin
              oe_d = 1'b0;
              st_d = ST_RACK;
            end else begin
              sh_d = {sh[BYTE_W-2:0], 1'b0};
              oe_d = ~sh[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (mack) begin
              sh_d   = rd_byte;
              oe_d   = ~rd_byte[BYTE_W-1];
              rsel_d = ~rd_sel;
              st_d   = ST_RDATA;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      sda_oe <= 1'b0;
      rd_sel <= 1'b0;
      rd     <= 1'b0;
      wr_stb <= 1'b0;
      mack   <= 1'b0;
    end else begin
      st     <= st_d;
      cnt    <= cnt_d;
      sh     <= sh_d;
      sda_oe <= oe_d;
      rd_sel <= rsel_d;
      rd     <= rd_d;
      wr_stb <= wstb_d;
      mack   <= mack_d;
    end
  end

  assign wr_data = sh[BYTE_W-1:1];

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && $past(pwr_good)) |-> !scl_s); // R5
  AST_NO_OE_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !sda_oe); // R8
endmodule

// File: rtl/lnb_sysreg.sv
module lnb_sysreg
  import lnbi2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              otf,
  input  logic              olf1,
  input  logic              olf2,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:1] wr_data,
  input  logic              rd_sel,
  output logic [CH1_W-1:0]  ctrl1,
  output logic [CH2_W-1:0]  ctrl2,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [CH1_W-1:0] w1_d;
  logic [CH2_W-1:0] w2_d;
  logic             otf_q, otf_rise;

  assign otf_rise = otf & ~otf_q;

  always_comb begin
    w1_d = ctrl1;
    w2_d = ctrl2;
    if (!pwr_good || otf_rise) begin
      w1_d = '0;
      w2_d = '0;
    end else if (wr_stb) begin
      if (wr_data[SEL_BIT]) w2_d = wr_data[CH2_W:1];
      else                  w1_d = wr_data[CH1_W:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl1 <= '0;
      ctrl2 <= '0;
      otf_q <= 1'b0;
    end else begin
      ctrl1 <= w1_d;
      ctrl2 <= w2_d;
      otf_q <= otf;
    end
  end

  assign rd_byte = rd_sel ? {1'b1, olf2, ctrl2, otf} : {1'b0, ctrl1, olf1};

  AST_PWR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (ctrl1 == '0 && ctrl2 == '0)); // R8
  AST_OTF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(otf) |=> (ctrl1 == '0 && ctrl2 == '0)); // R9
  AST_SEL_SPARES_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && pwr_good && !otf_rise && !wr_data[SEL_BIT]) |=> $stable(ctrl2)); // R3
endmodule

// File: rtl/lnb_ctrl_i2c.sv
module lnb_ctrl_i2c
  import lnbi2c_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_HI     = 6'b000100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       addr_sel,
  input  logic       pwr_good,
  input  logic       olf1,
  input  logic       olf2,
  input  logic       otf,
  output logic       dyn_limit,
  output logic [1:0] ilim_hi,
  output logic [1:0] tone_on,
  output logic [1:0] cable_comp,
  output logic [1:0] hi_volt,
  output logic [1:0] chan_en
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              rd_sel, wr_stb;
  logic [BYTE_W-1:1] wr_data;
  logic [BYTE_W-1:0] rd_byte;
  logic [CH1_W-1:0]  ctrl1;
  logic [CH2_W-1:0]  ctrl2;

  lnb_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  lnb_link_fsm #(.ADDR_HI(ADDR_HI)) u_link (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .addr_sel(addr_sel),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_byte(rd_byte),
    .rd_sel(rd_sel), .wr_stb(wr_stb), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  lnb_sysreg u_regs (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .otf(otf),
    .olf1(olf1), .olf2(olf2), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_sel(rd_sel), .ctrl1(ctrl1), .ctrl2(ctrl2), .rd_byte(rd_byte)
  );

  assign dyn_limit  = ctrl1[5];
  assign ilim_hi    = {ctrl2[4], ctrl1[4]};
  assign tone_on    = {ctrl2[3], ctrl1[3]};
  assign cable_comp = {ctrl2[2], ctrl1[2]};
  assign hi_volt    = {ctrl2[1], ctrl1[1]};
  assign chan_en    = {ctrl2[0], ctrl1[0]};
endmodule

// File: tb/lnb_ctrl_i2c_bench.sv
module lnb_ctrl_i2c_bench;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl = 1'b1, sda_m = 1'b1, addr_sel = 1'b0, pwr_good = 1'b1;
  logic olf1 = 1'b0, olf2 = 1'b0, otf = 1'b0;
  logic sda_oe, dyn_limit;
  logic [1:0] ilim_hi, tone_on, cable_comp, hi_volt, chan_en;
  wire line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  lnb_ctrl_i2c u_lnb_ctrl_i2c (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .pwr_good(pwr_good), .olf1(olf1), .olf2(olf2), .otf(otf),
    .dyn_limit(dyn_limit), .ilim_hi(ilim_hi), .tone_on(tone_on),
    .cable_comp(cable_comp), .hi_volt(hi_volt), .chan_en(chan_en)
  );

  // {data byte, expected {ch1 dyn,ilim,tone,comp,hv,en, ch2 ilim,tone,comp,hv,en}}
  localparam logic [18:0] VEC [6] = '{
    {8'h7E, 11'b111111_00000},
    {8'hBF, 11'b111111_11111},
    {8'h2A, 11'b010101_11111},
    {8'hD4, 11'b010101_01010},
    {8'h01, 11'b000000_01010},
    {8'hC3, 11'b000000_00001}
  };

  function automatic logic [10:0] ctrl_now();
    return {dyn_limit, ilim_hi[0], tone_on[0], cable_comp[0], hi_volt[0], chan_en[0],
            ilim_hi[1], tone_on[1], cable_comp[1], hi_volt[1], chan_en[1]};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; tick(Q);
    scl = 1'b1; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1; tick(Q / 2);
    b = line; tick(Q / 2);
    scl = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(a);
    ack = ~a;
  endtask

  task automatic rbyte(output logic [7:0] v, input logic more);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    wbit(~more);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d,
                          output logic aa, output logic da);
    bus_start();
    wbyte({a, 1'b0}, aa);
    da = 1'b0;
    if (aa) wbyte(d, da);
    bus_stop();
  endtask

  task automatic do_read(input logic [6:0] a, output logic aa,
                         output logic [7:0] b0, output logic [7:0] b1, output logic [7:0] b2);
    bus_start();
    wbyte({a, 1'b1}, aa);
    rbyte(b0, 1'b1);
    rbyte(b1, 1'b1);
    rbyte(b2, 1'b0);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic aa, da, da2;
    logic [7:0] b0, b1, b2;
    tick(5);
    check("R7 reset ctrl", 32'(ctrl_now()), 32'h0);
    check("R7 reset sda_oe", 32'(sda_oe), 32'h0);
    rst_n = 1'b1;
    tick(5);
    do_read(7'h08, aa, b0, b1, b2);
    check("R7 reset read ch1", 32'(b0), 32'h00);
    check("R7 reset read ch2", 32'(b1), 32'h80);

    // Table walk: writes through address 0001000
    for (int k = 0; k < 6; k++) begin
      do_write(7'h08, VEC[k][18:11], aa, da);
      check("R1 address ack", 32'(aa), 32'h1);
      check("R2 data ack", 32'(da), 32'h1);
      check("R3 control decode", 32'(ctrl_now()), 32'(VEC[k][10:0]));
    end

    // R1 wrong address ignored
    do_write(7'h09, 8'h7E, aa, da);
    check("R1 foreign address nack", 32'(aa), 32'h0);
    check("R1 foreign address no write", 32'(ctrl_now()), 32'(11'b000000_00001));

    // R1 address low bit from addr_sel
    addr_sel = 1'b1;
    tick(4);
    do_write(7'h09, 8'h7E, aa, da);
    check("R1 sel-high address ack", 32'(aa), 32'h1);
    check("R1 sel-high write", 32'(ctrl_now()), 32'(11'b111111_00001));
    do_write(7'h08, 8'h01, aa, da);
    check("R1 old address nack", 32'(aa), 32'h0);
    check("R1 old address no write", 32'(ctrl_now()), 32'(11'b111111_00001));
    addr_sel = 1'b0;
    tick(4);

    // R4 two data bytes in one write
    bus_start();
    wbyte(8'h10, aa);
    wbyte(8'h2A, da);
    wbyte(8'hD4, da2);
    bus_stop();
    check("R4 second byte ack", 32'(da2), 32'h1);
    check("R4 both bytes decoded", 32'(ctrl_now()), 32'(11'b010101_01010));

    // R5 R6 read order, live flags, wrap
    olf1 = 1'b1; olf2 = 1'b1;
    tick(4);
    do_read(7'h08, aa, b0, b1, b2);
    check("R5 read address ack", 32'(aa), 32'h1);
    check("R5 read ch1 byte", 32'(b0), 32'h2B);
    check("R6 second byte is ch2", 32'(b1), 32'hD4);
    check("R6 third byte wraps to ch1", 32'(b2), 32'h2B);
    check("R6 released after nack", 32'(sda_oe), 32'h0);

    // R9 overtemperature edge clears
    otf = 1'b1;
    tick(6);
    check("R9 otf clears controls", 32'(ctrl_now()), 32'h0);
    do_read(7'h08, aa, b0, b1, b2);
    check("R9 ch1 after otf", 32'(b0), 32'h01);
    check("R5 ch2 shows otf", 32'(b1), 32'hC1);
    otf = 1'b0; olf1 = 1'b0; olf2 = 1'b0;
    tick(4);

    // R8 power-good low
    do_write(7'h08, 8'h7E, aa, da);
    check("R8 setup write", 32'(ctrl_now()), 32'(11'b111111_00000));
    pwr_good = 1'b0;
    tick(4);
    check("R8 held zero", 32'(ctrl_now()), 32'h0);
    do_write(7'h08, 8'h7E, aa, da);
    check("R8 no ack unpowered", 32'(aa), 32'h0);
    check("R8 sda_oe low", 32'(sda_oe), 32'h0);
    pwr_good = 1'b1;
    tick(4);
    check("R8 write had no effect", 32'(ctrl_now()), 32'h0);
    do_read(7'h08, aa, b0, b1, b2);
    check("R8 ch1 reads zero", 32'(b0), 32'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule